// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a hierarchical translation table held in memory. Pages are 1 KiB, so the low ten address bits pass through unchanged as the offset. The remaining 22-bit page number is itself paged. Its top twelve bits pick an entry in a root table. That entry points at a second-level table, and the next ten bits pick the final entry there. The final entry gives the frame that holds the page.

A requester presents a logical address together with the root table base while the walker is ready. The walker then issues two dependent reads on a single memory read port whose latency may vary. It answers with a one-cycle response pulse that carries either the physical address or a fault flag, plus the level at which the walk stopped. Both table levels use the same 32-bit entry format: bit 0 is the valid flag and bits 31..10 hold a 1 KiB-aligned base, which is a table base at the root level and a frame base at the second level.

Top module: `ptw_two_level`

## Requirements
- R1: After a request is accepted, the first memory read goes to byte address `req_root + 4 * req_vaddr[31:20]`.
- R2: When the root entry has bit 0 set, the second read goes to `{entry[31:10], 10'b0} + 4 * req_vaddr[19:10]`. Entry bits 9..1 play no part in that address, and the second read is never issued before the first read has completed.
- R3: A root entry with bit 0 clear ends the walk with `rsp_fault = 1` and `rsp_fault_inner = 0`, and no second read is made.
- R4: A second-level entry with bit 0 clear ends the walk with `rsp_fault = 1` and `rsp_fault_inner = 1`.
- R5: A second-level entry with bit 0 set ends the walk with `rsp_fault = 0`, `rsp_fault_inner = 0` and `rsp_paddr = {entry[31:10], req_vaddr[9:0]}`.
- R6: `rsp_valid` is high for exactly one cycle: the cycle after the clock edge that takes in the read response ending the walk.
- R7: `req_ready` is high only while no walk is in progress. A `req_valid` seen while `req_ready` is low is ignored: it starts no read and no response.
- R8: `rsp_paddr` changes only when a walk completes without a fault. The fault flags change only when a walk completes. Between walks all three hold their values.
- R9: `mem_req` stays high and `mem_addr` stays unchanged from the first cycle of a read until the cycle in which `mem_rvalid` is high. A read completes in that cycle.
- R10: After reset the walker is ready, has no read outstanding, has no response pending, and shows zero on all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Logical address to translate |
| req_root | input | 32 | Byte address of the root table |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| mem_req | output | 1 | Table read outstanding |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk stopped on an invalid entry |
| rsp_fault_inner | output | 1 | 0: root level faulted, 1: second level faulted |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The root read request is due in the cycle after the edge that accepts a request. Each read completes in the cycle the memory model raises `mem_rvalid`, and the response pulse is due in the cycle after the edge that takes in the final read response. The bench's memory model flags the moment it delivers a walk's last entry. The monitor then expects `rsp_valid` at the very next falling edge, so a missing, late or doubled pulse is caught. All outputs are sampled on falling edges, half a period after the rising edge that changed them. Read addresses are compared when each read is served, with latencies from zero to several cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_OUTER = 3'd1,
        ST_RD_INNER = 3'd2,
        ST_DONE     = 3'd3,
        ST_FAULT    = 3'd4
    } walk_st_e;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int VA_W    = 32,
    parameter int PG_W    = 10,
    parameter int OUTER_W = 12,
    parameter int ENT_W   = 32
) (
    input  logic             sel_inner,
    input  logic [VA_W-1:0]  va,
    input  logic [ENT_W-1:0] root,
    input  logic [ENT_W-1:0] tbase,
    output logic [ENT_W-1:0] addr
);
    localparam int INNER_W   = VA_W - PG_W - OUTER_W;
    localparam int ENT_BYTES = ENT_W / 8;
    localparam int SH        = $clog2(ENT_BYTES);

    logic [OUTER_W-1:0] outer_idx;
    logic [INNER_W-1:0] inner_idx;
    logic [ENT_W-1:0]   idx_ext;
    logic [ENT_W-1:0]   base;

    assign outer_idx = va[VA_W-1 -: OUTER_W];
    assign inner_idx = va[PG_W +: INNER_W];

    always_comb begin
        base    = sel_inner ? tbase : root;
        idx_ext = sel_inner ? ENT_W'(inner_idx) : ENT_W'(outer_idx);
        addr    = base + (idx_ext << SH);
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int ENT_W = 32,
    parameter int PG_W  = 10
) (
    input  logic [ENT_W-1:0] ent,
    output logic             vld,
    output logic [ENT_W-1:0] page_base
);
    logic unused_attr;

    assign vld         = ent[0];
    assign page_base   = {ent[ENT_W-1:PG_W], {PG_W{1'b0}}};
    assign unused_attr = ^ent[PG_W-1:1];
endmodule

// File: rtl/ptw_two_level.sv
module ptw_two_level
    import ptw_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PG_W    = 10,
    parameter int OUTER_W = 12,
    parameter int ENT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [ENT_W-1:0] req_root,
    output logic             req_ready,
    output logic             mem_req,
    output logic [ENT_W-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic             rsp_fault_inner,
    output logic [ENT_W-1:0] rsp_paddr
);
    typedef struct packed {
        walk_st_e         st;
        logic [VA_W-1:0]  va;
        logic [ENT_W-1:0] root;
        logic [ENT_W-1:0] tbase;
        logic [ENT_W-1:0] pa;
        logic             flt;
        logic             flt_inner;
    } walk_t;

    walk_t s_d, s_q;

    logic             ent_vld;
    logic [ENT_W-1:0] ent_base;

    ptw_entry_addr #(
        .VA_W(VA_W), .PG_W(PG_W), .OUTER_W(OUTER_W), .ENT_W(ENT_W)
    ) u_addr (
        .sel_inner (s_q.st == ST_RD_INNER),
        .va        (s_q.va),
        .root      (s_q.root),
        .tbase     (s_q.tbase),
        .addr      (mem_addr)
    );

    ptw_pte_decode #(
        .ENT_W(ENT_W), .PG_W(PG_W)
    ) u_dec (
        .ent       (mem_rdata),
        .vld       (ent_vld),
        .page_base (ent_base)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st   = ST_RD_OUTER;
                    s_d.va   = req_vaddr;
                    s_d.root = req_root;
                end
            end
            ST_RD_OUTER: begin
                if (mem_rvalid) begin
                    if (ent_vld) begin
                        s_d.st    = ST_RD_INNER;
                        s_d.tbase = ent_base;
                    end else begin
                        s_d.st        = ST_FAULT;
                        s_d.flt       = 1'b1;
                        s_d.flt_inner = 1'b0;
                    end
                end
            end
            ST_RD_INNER: begin
                if (mem_rvalid) begin
                    if (ent_vld) begin
                        s_d.st        = ST_DONE;
                        s_d.flt       = 1'b0;
                        s_d.flt_inner = 1'b0;
                        s_d.pa        = {ent_base[ENT_W-1:PG_W], s_q.va[PG_W-1:0]};
                    end else begin
                        s_d.st        = ST_FAULT;
                        s_d.flt       = 1'b1;
                        s_d.flt_inner = 1'b1;
                    end
                end
            end
            ST_DONE, ST_FAULT: s_d.st = ST_IDLE;
            default:           s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign req_ready       = (s_q.st == ST_IDLE);
    assign mem_req         = (s_q.st == ST_RD_OUTER) || (s_q.st == ST_RD_INNER);
    assign rsp_valid       = (s_q.st == ST_DONE) || (s_q.st == ST_FAULT);
    assign rsp_fault       = s_q.flt;
    assign rsp_fault_inner = s_q.flt_inner;
    assign rsp_paddr       = s_q.pa;

    // R9: an outstanding read keeps its address until served
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R6: response strobe lasts one cycle and is followed by idle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R7: the captured address does not move while busy
    a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(s_q.va));

    // R8: translated address moves only on a completing second-level read
    a_r8_pa_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rvalid && s_q.st == ST_RD_INNER) |=> $stable(rsp_paddr));

    // R5: offset bits pass through on success
    a_r5_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PG_W-1:0] == s_q.va[PG_W-1:0]));

    // R3: a root-level fault comes straight from the root read
    a_r3_outer_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_fault_inner) |-> ($past(s_q.st) == ST_RD_OUTER));
endmodule

// File: tb/sim_ptw_two_level.sv
module sim_ptw_two_level;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        req_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic        rsp_fault_inner;
    logic [31:0] rsp_paddr;

    always #2.5 clk = ~clk;

    ptw_two_level u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_root(req_root),
        .req_ready(req_ready),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_fault_inner(rsp_fault_inner), .rsp_paddr(rsp_paddr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int n_rsp  = 0;

    typedef struct {
        logic [31:0] addr;
        bit          is_inner;
        bit          last;
    } rd_exp_t;

    typedef struct {
        bit          flt;
        bit          inner;
        logic [31:0] pa;
    } rsp_exp_t;

    rd_exp_t  rd_q[$];
    rsp_exp_t rsp_q[$];

    logic [31:0] mem [logic [31:0]];

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model with variable latency ----------------
    int          lat = 0;
    int          cnt = 0;
    bit          m_busy = 0;
    bit          m_last = 0;
    bit          due = 0;
    logic [31:0] m_held = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            cnt        <= 0;
            m_busy     = 0;
        end else if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            cnt        <= lat;
            if (m_last) due = 1;
        end else if (mem_req) begin
            if (!m_busy) begin
                m_busy = 1;
                m_held = mem_addr;
            end
            if (cnt == 0) begin
                rd_exp_t e;
                chk("R9 address held while outstanding", mem_addr, m_held);
                m_busy = 0;
                if (rd_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R7 unexpected read actual=%h expected=none", mem_addr);
                    m_last = 0;
                end else begin
                    e = rd_q.pop_front();
                    chk(e.is_inner ? "R2 second-level read address" : "R1 root read address",
                        mem_addr, e.addr);
                    m_last = e.last;
                end
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd_word(mem_addr);
            end else begin
                cnt <= cnt - 1;
            end
        end else begin
            cnt <= lat;
        end
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            if (due) begin
                chk("R6 response one cycle after final read", {31'b0, rsp_valid}, 32'd1);
                due = 0;
            end else if (rsp_valid) begin
                n_chk++; n_fail++;
                $display("FAIL R6 response at wrong time actual=1 expected=0");
            end
            if (rsp_valid) begin
                n_rsp++;
                if (rsp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R7 unexpected response actual=1 expected=0");
                end else begin
                    rsp_exp_t x;
                    string tg;
                    x  = rsp_q.pop_front();
                    tg = !x.flt ? "R5" : (x.inner ? "R4" : "R3");
                    chk({tg, " fault flag"}, {31'b0, rsp_fault}, {31'b0, x.flt});
                    chk({tg, " fault level"}, {31'b0, rsp_fault_inner}, {31'b0, x.inner});
                    if (!x.flt) chk("R5 physical address", rsp_paddr, x.pa);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input logic [31:0] va, input logic [31:0] rt);
        rd_exp_t     r;
        rsp_exp_t    x;
        logic [31:0] oa, oe, ia, ie;
        oa = rt + {18'b0, va[31:20], 2'b00};
        oe = rd_word(oa);
        r.addr = oa; r.is_inner = 0; r.last = !oe[0];
        rd_q.push_back(r);
        x.flt = 0; x.inner = 0; x.pa = '0;
        if (!oe[0]) begin
            x.flt = 1;
        end else begin
            ia = {oe[31:10], 10'b0} + {20'b0, va[19:10], 2'b00};
            ie = rd_word(ia);
            r.addr = ia; r.is_inner = 1; r.last = 1;
            rd_q.push_back(r);
            if (!ie[0]) begin
                x.flt = 1; x.inner = 1;
            end else begin
                x.pa = {ie[31:10], va[9:0]};
            end
        end
        rsp_q.push_back(x);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_root  = rt;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 ready low once a walk starts", {31'b0, req_ready}, 32'd0);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (rsp_q.size() != 0 || !req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    localparam logic [31:0] ROOT_A = 32'h0010_0000;
    localparam logic [31:0] ROOT_B = 32'h0080_0000;

    initial begin
        logic [31:0] va_a, held_pa;
        logic        held_f, held_fi;
        int          rsp_before;
        va_a = {12'h003, 10'h005, 10'h12A};

        mem[ROOT_A + 32'd12]            = 32'h0020_0001;
        mem[32'h0020_0000 + 32'd20]     = 32'h0ABC_D401;
        mem[ROOT_A + 32'h0000_3FFC]     = 32'h0030_03FF;
        mem[32'h0030_0000 + 32'h0FFC]   = 32'hFFFF_FFFF;
        mem[ROOT_A]                     = 32'h0040_0001;
        mem[32'h0040_0000]              = 32'h1234_5001;
        mem[ROOT_B + 32'd12]            = 32'h0050_0001;
        mem[32'h0050_0000 + 32'd20]     = 32'h7777_7C01;
        mem[32'h0020_0000 + 32'd36]     = 32'h5555_5400;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready",     {31'b0, req_ready}, 32'd1);
        chk("R10 reset no read",   {31'b0, mem_req},   32'd0);
        chk("R10 reset no strobe", {31'b0, rsp_valid}, 32'd0);
        chk("R10 reset fault",     {30'b0, rsp_fault, rsp_fault_inner}, 32'd0);
        chk("R10 reset address",   rsp_paddr, 32'd0);

        lat = 0; issue(va_a, ROOT_A); wait_done();
        lat = 3; issue({12'hFFF, 10'h3FF, 10'h3FF}, ROOT_A); wait_done();
        lat = 1; issue(32'h0000_0000, ROOT_A); wait_done();
        lat = 2; issue(va_a, ROOT_B); wait_done();
        lat = 0; issue({12'h007, 10'h005, 10'h001}, ROOT_A); wait_done();
        lat = 4; issue({12'h003, 10'h009, 10'h0FF}, ROOT_A); wait_done();

        // R8: hold after success, then unaffected by a faulting walk
        lat = 1; issue(va_a, ROOT_A); wait_done();
        held_pa = rsp_paddr; held_f = rsp_fault; held_fi = rsp_fault_inner;
        repeat (6) @(negedge clk);
        chk("R8 address held while idle", rsp_paddr, held_pa);
        chk("R8 flags held while idle", {30'b0, rsp_fault, rsp_fault_inner},
            {30'b0, held_f, held_fi});
        lat = 2; issue({12'h009, 10'h000, 10'h000}, ROOT_A); wait_done();
        chk("R8 address kept across fault", rsp_paddr, held_pa);

        // R7: requests while busy are ignored
        rsp_before = n_rsp;
        lat = 4; issue(va_a, ROOT_A);
        req_valid = 1'b1;
        req_vaddr = {12'h00A, 10'h001, 10'h002};
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk("R7 one response for busy-time strobes", n_rsp - rsp_before, 32'd1);
        chk("R7 no extra reads pending", rd_q.size(), 32'd0);

        // back-to-back walks with varied latency
        lat = 0; issue({12'hFFF, 10'h3FF, 10'h155}, ROOT_A); wait_done();
        lat = 5; issue(va_a, ROOT_B); wait_done();

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule